// File: doc/BRIEF.md
# Prioritized interrupt entry sequencer

This block runs the entry into an interrupt for a small 8-bit microcontroller core. It keeps a latched reset request and a set of pending hardware interrupt sources. When the core's global interrupt enable is high, it picks one request to serve. A reset request always comes before any hardware source. Among the hardware sources, the lowest-numbered pending one is served first.

Once a request is accepted, the block captures the current word program counter and stack pointer. It writes the return address to data memory one byte per clock, low byte first, and steps the stack address down after each byte. In the cycle after the last byte it presents the new program counter and the updated stack pointer. In that same cycle it raises a one-cycle strobe that loads them and a one-cycle pulse that tells the core to clear its global enable.

Three parameters shape the block. The vector spacing is one word, or two words when long jump/call support is configured. The number of pushed bytes is set by the program counter width. The number of hardware sources is also a parameter.

The controller has three states:
- IDLE: waiting for a request.
- PUSH: writing one return-address byte per cycle while a down-counter of remaining bytes runs.
- LOAD: presenting the new program counter.

Its transitions are:
- IDLE→PUSH on accept.
- PUSH→PUSH while bytes remain.
- PUSH→LOAD on the last byte.
- LOAD→IDLE unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: No entry of any kind is started while `gie_i` is low. Pending hardware bits and a latched reset request are kept until entry is allowed.
- R2: A reset request pulse on `reset_req_i` is latched. When entry is allowed, it is served before any hardware source, with vector number 0. Pending hardware bits are left untouched.
- R3: When no reset request is latched, the lowest-numbered set bit of the pending set is served. Its vector number is the bit index plus one.
- R4: The new program counter `pc_o` equals the vector number times the entry size. The entry size is 2 words when `LONG_VEC`=1 and 1 word when `LONG_VEC`=0.
- R5: The return program counter is written low byte first, one byte per consecutive cycle. The first write is in the cycle after acceptance and goes to address `sp_i`. Each later write goes to the previous address minus one.
- R6: The number of bytes written is 3 when `PC_W`>16, 2 when 8<`PC_W`<=16, and 1 otherwise. `sp_o` at load equals `sp_i` minus that count.
- R7: On load, `gie_clr_o` pulses high. Only the served bit leaves `pending_o`: the reset latch for a reset entry, or the one hardware bit otherwise.
- R8: `hw_req_o` is high exactly while `pending_o` is non-zero.
- R9: `pc_load_o` is a one-cycle strobe in the cycle right after the last byte write. `busy_o` is high from the first write through the load cycle.
- R10: Bits raised on `irq_raise_i` during the push sequence are added to the pending set. They do not change the vector already chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_req_i | input | 1 | Reset-entry request pulse, latched |
| irq_raise_i | input | NUM_SRC | Per-source raise pulses, ORed into the pending set |
| gie_i | input | 1 | Core global interrupt enable |
| pc_i | input | PC_W | Current word program counter (return address) |
| sp_i | input | SP_W | Current stack pointer |
| mem_we_o | output | 1 | Data-memory write strobe for a pushed byte |
| mem_addr_o | output | SP_W | Data-memory write address |
| mem_wdata_o | output | 8 | Data-memory write byte |
| pc_o | output | PC_W | Target program counter |
| pc_load_o | output | 1 | One-cycle strobe: load `pc_o` and `sp_o` |
| sp_o | output | SP_W | Stack pointer after the pushes |
| gie_clr_o | output | 1 | One-cycle request to clear the global enable |
| busy_o | output | 1 | Entry sequence in progress |
| pending_o | output | NUM_SRC | Current pending hardware set |
| hw_req_o | output | 1 | Hardware request, high while any bit is pending |

## Verification
The bench builds the block with `NUM_SRC`=4, `PC_W`=22 and `LONG_VEC`=1. This makes every one of the 15 non-empty pending patterns reachable, and each is drained source by source. It also exercises the longest three-byte push and the two-word vector spacing, where a wrong multiplier or byte order shows up. Reset requests are combined with pending hardware bits and with a cleared enable. A raise is injected in the middle of a push to show that it is latched without disturbing the vector already chosen.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_e;

    // number of return-address bytes for a given program counter width
    function automatic int push_bytes(input int pc_w);
        if (pc_w > 16)
            return 3;
        else if (pc_w > 8)
            return 2;
        else
            return 1;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raise_i,
    input  logic               rst_set_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic               rst_clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               rst_pend_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic               rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_mask_i) | raise_i;
            rst_q  <= (rst_q & ~rst_clr_i) | rst_set_i;
        end
    end

    assign pend_o     = pend_q;
    assign rst_pend_o = rst_q;

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_SRC-1:0] onehot_o
);

    // prefix OR from bit 0 upward: a bit wins when no lower bit is set
    logic [NUM_SRC:0] below;
    assign below[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        assign onehot_o[g]  = pend_i[g] & ~below[g];
        assign below[g + 1] = below[g] | pend_i[g];
    end

    assign any_o = below[NUM_SRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (onehot_o[i])
                idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_push_path.sv
module irq_push_path #(
    parameter int PC_W   = 16,
    parameter int SP_W   = 16,
    parameter int NBYTES = 2,
    parameter int CNT_W  = $clog2(NBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [SP_W-1:0]  sp_i,
    output logic [7:0]       byte_o,
    output logic [SP_W-1:0]  sp_o,
    output logic             last_o
);

    localparam int RET_W = 8 * NBYTES;

    logic [RET_W-1:0] ret_q;
    logic [SP_W-1:0]  sp_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= '0;
            sp_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            ret_q <= RET_W'(pc_i);
            sp_q  <= sp_i;
            cnt_q <= CNT_W'(NBYTES);
        end else if (step_i) begin
            ret_q <= ret_q >> 8;
            sp_q  <= sp_q - SP_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign byte_o = ret_q[7:0];
    assign sp_o   = sp_q;
    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int PC_W     = 16,
    parameter int SP_W     = 16,
    parameter bit LONG_VEC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req_i,
    input  logic [NUM_SRC-1:0] irq_raise_i,
    input  logic               gie_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [SP_W-1:0]    sp_i,
    output logic               mem_we_o,
    output logic [SP_W-1:0]    mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    output logic [PC_W-1:0]    pc_o,
    output logic               pc_load_o,
    output logic [SP_W-1:0]    sp_o,
    output logic               gie_clr_o,
    output logic               busy_o,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               hw_req_o
);

    localparam int NBYTES = push_bytes(PC_W);
    localparam int ENTRY  = LONG_VEC ? 2 : 1;
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VEC_W  = $clog2(NUM_SRC + 1);

    seq_state_e state_q, state_d;

    logic               rst_pend;
    logic [NUM_SRC-1:0] pend;
    logic               hw_any;
    logic [IDX_W-1:0]   win_idx;
    logic [NUM_SRC-1:0] win_oh;
    logic               accept;
    logic               take_rst;
    logic [NUM_SRC-1:0] clr_mask;
    logic [VEC_W-1:0]   vec_q;
    logic [7:0]         push_byte;
    logic [SP_W-1:0]    sp_cur;
    logic               push_last;

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (irq_raise_i),
        .rst_set_i  (reset_req_i),
        .clr_mask_i (clr_mask),
        .rst_clr_i  (take_rst),
        .pend_o     (pend),
        .rst_pend_o (rst_pend)
    );

    irq_low_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend_i   (pend),
        .any_o    (hw_any),
        .idx_o    (win_idx),
        .onehot_o (win_oh)
    );

    irq_push_path #(.PC_W(PC_W), .SP_W(SP_W), .NBYTES(NBYTES)) u_push (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (state_q == ST_PUSH),
        .pc_i   (pc_i),
        .sp_i   (sp_i),
        .byte_o (push_byte),
        .sp_o   (sp_cur),
        .last_o (push_last)
    );

    assign accept   = (state_q == ST_IDLE) && gie_i && (rst_pend || hw_any);
    assign take_rst = accept && rst_pend;
    assign clr_mask = (accept && !rst_pend) ? win_oh : '0;

    // vector capture at acceptance; frozen until the next acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vec_q <= '0;
        else if (accept)
            vec_q <= rst_pend ? '0 : VEC_W'(win_idx) + VEC_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_PUSH;
            ST_PUSH: if (push_last) state_d = ST_LOAD;
            ST_LOAD:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_we_o  = 1'b0;
        pc_load_o = 1'b0;
        gie_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH: mem_we_o = 1'b1;
            ST_LOAD: begin
                pc_load_o = 1'b1;
                gie_clr_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign mem_addr_o  = sp_cur;
    assign mem_wdata_o = push_byte;
    assign pc_o        = PC_W'(vec_q) * PC_W'(ENTRY);
    assign sp_o        = sp_cur;
    assign pending_o   = pend;
    assign hw_req_o    = hw_any;

    AST_ENTRY_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(gie_i)); // R1

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SP_W'(1))); // R5

    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> ($past(mem_we_o) && !$past(mem_we_o, NBYTES + 1))); // R6

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o); // R9

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(vec_q)); // R10

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 4;
    localparam int PCW  = 22;
    localparam int SPW  = 16;
    localparam int NB   = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reset_req_i = 1'b0;
    logic [NS-1:0]  irq_raise_i = '0;
    logic           gie_i = 1'b0;
    logic [PCW-1:0] pc_i = '0;
    logic [SPW-1:0] sp_i = '0;
    logic           mem_we_o;
    logic [SPW-1:0] mem_addr_o;
    logic [7:0]     mem_wdata_o;
    logic [PCW-1:0] pc_o;
    logic           pc_load_o;
    logic [SPW-1:0] sp_o;
    logic           gie_clr_o;
    logic           busy_o;
    logic [NS-1:0]  pending_o;
    logic           hw_req_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_entry_seq #(.NUM_SRC(NS), .PC_W(PCW), .SP_W(SPW), .LONG_VEC(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .reset_req_i(reset_req_i), .irq_raise_i(irq_raise_i),
        .gie_i(gie_i), .pc_i(pc_i), .sp_i(sp_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .pc_o(pc_o),
        .pc_load_o(pc_load_o), .sp_o(sp_o), .gie_clr_o(gie_clr_o), .busy_o(busy_o),
        .pending_o(pending_o), .hw_req_o(hw_req_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_pend(input logic [NS-1:0] m);
        @(negedge clk) irq_raise_i = m;
        @(negedge clk) irq_raise_i = '0;
    endtask

    // one entry: vec expected, expected pending at load, optional mid-push raise
    task automatic run_entry(input int vec, input logic [PCW-1:0] pc,
                             input logic [SPW-1:0] sp, input logic [NS-1:0] exp_pend,
                             input logic [NS-1:0] mid_raise);
        int k = 0;
        bit got = 1'b0;
        @(negedge clk);
        pc_i = pc; sp_i = sp; gie_i = 1'b1;
        for (int c = 0; c < 10 && !got; c++) begin
            @(negedge clk);
            irq_raise_i = '0;
            if (mem_we_o) begin
                chk(mem_addr_o == sp - SPW'(k), "R5", "push address", mem_addr_o, sp - SPW'(k));
                chk(mem_wdata_o == 8'((pc >> (8 * k)) & 22'hff), "R5", "push byte",
                    mem_wdata_o, (pc >> (8 * k)) & 22'hff);
                chk(busy_o == 1'b1, "R9", "busy during push", busy_o, 1);
                if (k == 0 && mid_raise != '0) irq_raise_i = mid_raise;
                k++;
            end
            if (pc_load_o) begin
                got = 1'b1;
                chk(k == NB, "R6", "byte count", k, NB);
                chk(sp_o == sp - SPW'(NB), "R6", "final sp", sp_o, sp - SPW'(NB));
                chk(pc_o == PCW'(2 * vec), "R4", "target pc", pc_o, 2 * vec);
                chk(gie_clr_o == 1'b1, "R7", "gie clear", gie_clr_o, 1);
                chk(pending_o == exp_pend, "R7", "pending after entry", pending_o, exp_pend);
                chk(hw_req_o == (exp_pend != '0), "R8", "hw request", hw_req_o, exp_pend != '0);
                gie_i = 1'b0;
            end
        end
        if (!got) chk(1'b0, "R9", "load strobe missing", 0, 1);
        @(negedge clk);
        chk(pc_load_o == 1'b0 && busy_o == 1'b0, "R9", "strobe ends", pc_load_o, 0);
    endtask

    function automatic int lowest(input logic [NS-1:0] m);
        for (int i = 0; i < NS; i++) if (m[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we_o && !pc_load_o && !busy_o && pending_o == '0 && !hw_req_o,
            "R8", "reset state", {mem_we_o, pc_load_o, busy_o, hw_req_o}, 0);

        // R1: enable low blocks both kinds of entry
        load_pend(4'b0101);
        @(negedge clk) reset_req_i = 1'b1;
        @(negedge clk) reset_req_i = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(!mem_we_o && !busy_o, "R1", "no entry while disabled", mem_we_o, 0);
        end
        chk(pending_o == 4'b0101, "R1", "pending kept", pending_o, 4'b0101);

        // R2: reset entry first, vector 0, hardware bits untouched
        run_entry(0, 22'h2a_bc_de, 16'h08ff, 4'b0101, '0);
        // R3: then the hardware bits in order
        run_entry(1, 22'h01_23_45, 16'h0800, 4'b0100, '0);
        run_entry(3, 22'h3f_00_ff, 16'h0400, 4'b0000, '0);

        // R3 R4 R7 R8: sweep every non-empty pattern and drain it
        for (int p = 1; p < (1 << NS); p++) begin
            logic [NS-1:0] m;
            m = NS'(p);
            load_pend(m);
            @(negedge clk);
            chk(pending_o == m && hw_req_o, "R8", "pattern loaded", pending_o, m);
            while (m != '0) begin
                int lo;
                lo = lowest(m);
                m[lo] = 1'b0;
                run_entry(lo + 1, PCW'(p * 22'h01_11_11 + lo), SPW'(16'h1000 + 16'h10 * p),
                          m, '0);
            end
            chk(hw_req_o == 1'b0, "R8", "drained", hw_req_o, 0);
        end

        // R10: raise of a lower bit during push does not alter the chosen vector
        load_pend(4'b0100);
        run_entry(3, 22'h15_a5_5a, 16'h0200, 4'b0001, 4'b0001);
        run_entry(1, 22'h00_00_07, 16'h0300, 4'b0000, '0);

        // R2 with no hardware pending
        @(negedge clk) reset_req_i = 1'b1;
        @(negedge clk) reset_req_i = 1'b0;
        run_entry(0, 22'h00_12_34, 16'h0100, 4'b0000, '0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule